// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns nine raw interrupt pins into clean interrupt requests for the interrupt acknowledge logic. One pin is non-maskable (NMI). The other eight are maskable IRQ pins, numbered 0 to 7. Each pin passes through a synchroniser. A 16-bit control register then sets how each synchronised pin is sensed. The NMI pin is always edge-sensed, and one register bit picks the polarity of that edge. Each IRQ pin is sensed either as an active-low level or as a falling edge.

An edge request stays latched until the acknowledge logic sends a one-cycle clear strobe for that source. A level request simply follows the synchronised pin and needs no clear. The register is written through a plain write-enable port and can be read at any time. Its top bit shows the live, synchronised NMI level. A reset puts the register back to its initial values. A low-power standby input freezes the register so that its contents survive entering and leaving standby.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, `rd_data` reads 16'h8000 while all pins are high: NMI polarity is falling edge, every IRQ is in level mode, and no request is asserted.
- R2: `rd_data[15]` returns the NMI pin level after two clock edges of synchronisation: 1 for high, 0 for low. Writing this bit has no effect.
- R3: `rd_data[14:9]` always reads 0, whatever value is written there.
- R4: A write with `wr_en` high and `standby` low is visible at the next clock. Bit 8 holds the NMI polarity. Bit 7-i holds the mode of IRQi (1 = falling edge, 0 = low level), so bit 7 controls IRQ0 and bit 0 controls IRQ7.
- R5: When bit 8 is 0, a falling edge on the NMI pin sets `nmi_req` and a rising edge does not. When bit 8 is 1, the reverse holds. `nmi_req` rises on the third clock edge after the pin changes.
- R6: `nmi_req` stays high until an `nmi_clr` pulse arrives. If a new qualifying edge arrives in the same cycle as the clear, the request stays set.
- R7: In level mode, `irq_req[i]` is high while the synchronised IRQi pin is low, appearing two clock edges after the pin changes. `irq_clr` has no effect on it.
- R8: In edge mode, a falling edge on IRQi latches `irq_req[i]`. A rising edge neither sets nor clears it, and only `irq_clr[i]` clears it.
- R9: A write that moves an IRQ from edge mode to level mode discards any latched request for that IRQ. Returning the IRQ to edge mode therefore shows no request.
- R10: An edge detected in the same cycle as a register write is judged against the setting in force before that write.
- R11: While `standby` is high, the register keeps its contents and ignores writes. Leaving standby does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Low-power standby; freezes the control register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value with live NMI level |
| nmi_pin | input | 1 | Raw NMI pin |
| irq_pin | input | 8 | Raw IRQ pins, bit i is IRQi |
| nmi_clr | input | 1 | One-cycle clear of the latched NMI request |
| irq_clr | input | 8 | One-cycle clears of latched IRQ requests, bit i is IRQi |
| nmi_req | output | 1 | NMI request |
| irq_req | output | 8 | IRQ requests, bit i is IRQi |

## Verification
A corrupted mode or polarity bit appears on `rd_data` in the very next cycle, and it also changes the request behaviour for that pin. A stale or lost latch shows on `irq_req` or `nmi_req` no more than three cycles after the edge that should have set it. A latch that survives a mode change stays hidden while the IRQ is in level mode and appears the moment the IRQ is put back into edge mode. The sweep covers each IRQ in both modes. For each one it checks the exact cycle a request appears, that only its own clear has any effect, and that a latch dropped by the edge-to-level change does not come back.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int unsigned IRQ_CNT    = 8;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned NMIL_POS   = 15;
    localparam int unsigned NMIE_POS   = 8;
    localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
    parameter int unsigned WIDTH  = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Pins idle high, so every stage resets to 1.
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqs_ctrl_reg.sv
module irqs_ctrl_reg
    import irqs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = IRQ_CNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standby,
    input  logic                wr_en,
    input  logic [NMIE_POS:0]   wr_bits,
    output logic                nmi_rise_sel,
    output logic [NUM_IRQ-1:0]  irq_edge_sel,
    output logic [NUM_IRQ-1:0]  irq_to_level
);
    typedef struct packed {
        logic               nmie;
        logic [NUM_IRQ-1:0] edge_sel;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic               wr_ok;
    logic [NUM_IRQ-1:0] new_sel;

    always_comb begin
        wr_ok = wr_en & ~standby;
        for (int i = 0; i < NUM_IRQ; i++) begin
            new_sel[i] = wr_bits[NUM_IRQ-1-i];   // IRQi sits at bit NUM_IRQ-1-i
        end
        st_d = st_q;
        irq_to_level = '0;
        if (wr_ok) begin
            st_d.nmie     = wr_bits[NMIE_POS];
            st_d.edge_sel = new_sel;
            irq_to_level  = st_q.edge_sel & ~new_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_rise_sel = st_q.nmie;
    assign irq_edge_sel = st_q.edge_sel;

    AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(st_q)) else $error("standby changed register"); // R11
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !standby) |=> (nmi_rise_sel == $past(wr_bits[NMIE_POS])))
        else $error("write lost"); // R4
endmodule

// File: rtl/irqs_detect.sv
module irqs_detect
    import irqs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = IRQ_CNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_s,
    input  logic [NUM_IRQ-1:0] irq_s,
    input  logic               nmi_rise_sel,
    input  logic [NUM_IRQ-1:0] irq_edge_sel,
    input  logic [NUM_IRQ-1:0] irq_to_level,
    input  logic               nmi_clr,
    input  logic [NUM_IRQ-1:0] irq_clr,
    output logic               nmi_req,
    output logic [NUM_IRQ-1:0] irq_req
);
    typedef struct packed {
        logic               nmi_prev;
        logic               nmi_pend;
        logic [NUM_IRQ-1:0] irq_prev;
        logic [NUM_IRQ-1:0] irq_pend;
    } det_t;

    det_t               det_d, det_q;
    logic               nmi_hit;
    logic [NUM_IRQ-1:0] irq_fall;

    always_comb begin
        nmi_hit  = nmi_rise_sel ? (nmi_s & ~det_q.nmi_prev) : (~nmi_s & det_q.nmi_prev);
        irq_fall = det_q.irq_prev & ~irq_s & irq_edge_sel;
        det_d.nmi_prev = nmi_s;
        det_d.irq_prev = irq_s;
        det_d.nmi_pend = nmi_hit | (det_q.nmi_pend & ~nmi_clr);
        det_d.irq_pend = ((det_q.irq_pend & ~irq_clr) | irq_fall) & ~irq_to_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.nmi_prev <= 1'b1;
            det_q.nmi_pend <= 1'b0;
            det_q.irq_prev <= '1;
            det_q.irq_pend <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign nmi_req = det_q.nmi_pend;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq_out
        assign irq_req[g] = irq_edge_sel[g] ? det_q.irq_pend[g] : ~irq_s[g];
    end

    AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q.nmi_pend && !nmi_clr) |=> det_q.nmi_pend) else $error("nmi lost"); // R6
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det_q.irq_pend & ~irq_clr & ~irq_to_level) & ~det_q.irq_pend) == '0))
        else $error("irq latch lost"); // R8
    AST_LEVEL_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_to_level) |=> ((det_q.irq_pend & $past(irq_to_level)) == '0))
        else $error("stale latch"); // R9
    AST_NMI_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q.nmi_pend) |-> ($past(nmi_s) != $past(det_q.nmi_prev)))
        else $error("nmi without edge"); // R5
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import irqs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = IRQ_CNT,
    parameter int unsigned STAGES  = SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               nmi_pin,
    input  logic [NUM_IRQ-1:0] irq_pin,
    input  logic               nmi_clr,
    input  logic [NUM_IRQ-1:0] irq_clr,
    output logic               nmi_req,
    output logic [NUM_IRQ-1:0] irq_req
);
    // NUM_IRQ must not exceed NMIE_POS so the mode bits stay below bit 8.
    localparam int unsigned PINS = NUM_IRQ + 1;

    logic [PINS-1:0]    pins_s;
    logic               nmi_s;
    logic [NUM_IRQ-1:0] irq_s;
    logic               nmi_rise_sel;
    logic [NUM_IRQ-1:0] irq_edge_sel;
    logic [NUM_IRQ-1:0] irq_to_level;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data[REG_W-1:NMIE_POS+1];

    irqs_sync #(.WIDTH(PINS), .STAGES(STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({nmi_pin, irq_pin}),
        .dout (pins_s)
    );

    assign nmi_s = pins_s[PINS-1];
    assign irq_s = pins_s[NUM_IRQ-1:0];

    irqs_ctrl_reg #(.NUM_IRQ(NUM_IRQ)) i_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby     (standby),
        .wr_en       (wr_en),
        .wr_bits     (wr_data[NMIE_POS:0]),
        .nmi_rise_sel(nmi_rise_sel),
        .irq_edge_sel(irq_edge_sel),
        .irq_to_level(irq_to_level)
    );

    irqs_detect #(.NUM_IRQ(NUM_IRQ)) i_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_s       (nmi_s),
        .irq_s       (irq_s),
        .nmi_rise_sel(nmi_rise_sel),
        .irq_edge_sel(irq_edge_sel),
        .irq_to_level(irq_to_level),
        .nmi_clr     (nmi_clr),
        .irq_clr     (irq_clr),
        .nmi_req     (nmi_req),
        .irq_req     (irq_req)
    );

    always_comb begin
        rd_data = '0;
        rd_data[NMIL_POS] = nmi_s;
        rd_data[NMIE_POS] = nmi_rise_sel;
        for (int i = 0; i < NUM_IRQ; i++) begin
            rd_data[NUM_IRQ-1-i] = irq_edge_sel[i];
        end
    end

    AST_LEVEL_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(~irq_edge_sel) & ~irq_edge_sel) & (irq_req ^ ~irq_s)) == '0))
        else $error("level request wrong"); // R7
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        nmi_pin = 1'b1;
    logic [7:0]  irq_pin = 8'hFF;
    logic        nmi_clr = 1'b0;
    logic [7:0]  irq_clr = '0;
    logic        nmi_req;
    logic [7:0]  irq_req;

    int pass_cnt = 0;
    int fail_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_sense i_ext_irq_sense (
        .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .nmi_pin(nmi_pin),
        .irq_pin(irq_pin), .nmi_clr(nmi_clr), .irq_clr(irq_clr),
        .nmi_req(nmi_req), .irq_req(irq_req)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        if (act === exp) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check(rd_data, 16'h8000, "R1 reset read");
        check({7'd0, nmi_req, irq_req}, 16'h0000, "R1 reset requests");

        // R2 R3 R4 sweep of single bits and patterns
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = 16'(1) << k;
            wr(v);
            check(rd_data, 16'h8000 | (v & 16'h01FF), "R2 R3 R4 single bit write");
        end
        wr(16'hFFFF); check(rd_data, 16'h81FF, "R3 R4 all ones");
        wr(16'h7E5A); check(rd_data, 16'h805A, "R3 R4 pattern");
        wr(16'h0000); check(rd_data, 16'h8000, "R2 R4 zero");

        // R5 falling edge with polarity 0, exact timing
        nmi_pin = 1'b0;
        step(1); check({15'd0, rd_data[15]}, 16'd1, "R2 level not yet");
        check({15'd0, nmi_req}, 16'd0, "R5 not yet");
        step(1); check({15'd0, rd_data[15]}, 16'd0, "R2 level low");
        check({15'd0, nmi_req}, 16'd0, "R5 edge seen next");
        step(1); check({15'd0, nmi_req}, 16'd1, "R5 falling latched");
        step(3); check({15'd0, nmi_req}, 16'd1, "R6 held");
        nmi_clr = 1'b1; step(1); nmi_clr = 1'b0;
        check({15'd0, nmi_req}, 16'd0, "R6 cleared");
        nmi_pin = 1'b1; step(4);
        check({15'd0, nmi_req}, 16'd0, "R5 rising ignored pol0");
        check({15'd0, rd_data[15]}, 16'd1, "R2 level high");

        // R5 polarity 1
        wr(16'h0100);
        nmi_pin = 1'b0; step(4);
        check({15'd0, nmi_req}, 16'd0, "R5 falling ignored pol1");
        nmi_pin = 1'b1; step(3);
        check({15'd0, nmi_req}, 16'd1, "R5 rising latched pol1");
        // R6 new edge with clear in same cycle
        nmi_pin = 1'b0; step(4);
        check({15'd0, nmi_req}, 16'd1, "R6 held through falling");
        nmi_pin = 1'b1; step(2);
        nmi_clr = 1'b1; step(1); nmi_clr = 1'b0;
        check({15'd0, nmi_req}, 16'd1, "R6 set wins over clear");
        nmi_clr = 1'b1; step(1); nmi_clr = 1'b0;
        check({15'd0, nmi_req}, 16'd0, "R6 cleared again");

        // R10 write in edge cycle uses old setting
        nmi_pin = 1'b0; step(2);
        wr(16'h0000);
        check({15'd0, nmi_req}, 16'd0, "R10 old rising setting");
        check({15'd0, rd_data[8]}, 16'd0, "R10 write landed");
        nmi_pin = 1'b1; step(4);
        check({15'd0, nmi_req}, 16'd0, "R5 rising ignored after write");
        nmi_pin = 1'b0; step(2);
        wr(16'h0100);
        check({15'd0, nmi_req}, 16'd1, "R10 old falling setting");
        nmi_clr = 1'b1; step(1); nmi_clr = 1'b0;
        nmi_pin = 1'b1; step(4);
        wr(16'h0000);
        nmi_clr = 1'b1; step(1); nmi_clr = 1'b0;
        check({15'd0, nmi_req}, 16'd0, "R6 idle");

        // IRQ sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] me;
            me = 8'(1) << i;
            // R7 level mode
            irq_pin[i] = 1'b0;
            step(1); check({8'd0, irq_req}, 16'h0000, "R7 level not yet");
            step(1); check({8'd0, irq_req}, {8'd0, me}, "R7 level asserted");
            irq_clr = 8'hFF; step(1); irq_clr = '0;
            check({8'd0, irq_req}, {8'd0, me}, "R7 clear ignored");
            irq_pin[i] = 1'b1; step(2);
            check({8'd0, irq_req}, 16'h0000, "R7 level released");
            // R4 mapping and R8 edge mode
            wr({8'd0, 8'(8'h80 >> i)});
            check(rd_data, 16'h8000 | {8'd0, 8'(8'h80 >> i)}, "R4 reversed mapping");
            irq_pin[i] = 1'b0;
            step(2); check({8'd0, irq_req}, 16'h0000, "R8 edge not yet");
            step(1); check({8'd0, irq_req}, {8'd0, me}, "R8 falling latched");
            irq_pin[i] = 1'b1; step(3);
            check({8'd0, irq_req}, {8'd0, me}, "R8 rising keeps latch");
            irq_clr = ~me; step(1); irq_clr = '0;
            check({8'd0, irq_req}, {8'd0, me}, "R8 other clears ignored");
            irq_clr = me; step(1); irq_clr = '0;
            check({8'd0, irq_req}, 16'h0000, "R8 own clear");
            irq_pin[i] = 1'b0; step(3); irq_pin[i] = 1'b1; step(3);
            check({8'd0, irq_req}, {8'd0, me}, "R8 latched again");
            // R9 edge to level drops latch
            wr(16'h0000);
            check({8'd0, irq_req}, 16'h0000, "R9 level mode idle");
            wr({8'd0, 8'(8'h80 >> i)});
            check({8'd0, irq_req}, 16'h0000, "R9 no stale latch");
            wr(16'h0000);
        end

        // R11 standby
        wr(16'h01A5);
        standby = 1'b1; step(3);
        check(rd_data, 16'h81A5, "R11 held in standby");
        wr(16'h0042);
        check(rd_data, 16'h81A5, "R11 write ignored in standby");
        standby = 1'b0; step(1);
        check(rd_data, 16'h81A5, "R11 held after standby");
        wr(16'h0042);
        check(rd_data, 16'h8042, "R11 write after standby");

        // R1 reset again
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        check(rd_data, 16'h8000, "R1 reset clears register");

        summary();
    end
endmodule